// File: doc/BRIEF.md
# Hot-Plug Controller Poll Sequencer

This block runs the background polling loop for a hot-plug controller. It sleeps for a fixed number of prescaler ticks, then runs one poll. Most polls are cheap: they read only the latch register and compare it with the previous sample. Every sixth poll is a full sweep instead. It reads the status and the extended status of every slot from the first slot number to the last. After each poll the block goes back to sleep.

The block talks to the controller through a byte-read port with one request in flight. The request goes to a register-access engine, which answers with read data and a one-cycle acknowledge. The block never touches a slot register while the controller is busy. Before each access it reads the controller status register until the busy flag clears. If the flag stays set for too many tries, it raises a one-cycle timeout pulse and drops the rest of that poll.

When a latch poll finds that a slot's latch bit has changed, the block reports it as a change event naming that slot. Deciding what a slot's status means is left to the logic downstream.

Top module: `hp_poll_seq`

## Requirements
- R1: Polls follow the repeating pattern of five latch polls, then one full sweep. This counts from reset and includes polls cut short by a timeout. The first poll after reset is a latch poll.
- R2: Between the end of one poll and the first request of the next, exactly SLEEP_TICKS tick pulses are seen while no request and no change event is active. The same gap precedes the first poll after reset.
- R3: A latch poll makes exactly one target read, at index 0x28.
- R4: A full sweep makes target reads in this order, with slot s counting up from first_slot to last_slot: first slot s at index s, then its extended status at index s + 0x10. The first slot number is at least 1 and is no larger than the last slot number.
- R5: Every target read comes right after a controller-status read at index 0x0F that returned bit 0 (busy) = 0. Every other bit of that status byte is ignored.
- R6: After a status read with bit 0 = 1, the block waits exactly RETRY_TICKS ticks with no request, then reads status at 0x0F again.
- R7: If MAX_RETRY status reads in a row within one wait all return busy, timeout_err is high for exactly the one cycle after the last of them. The poll is then abandoned: no target read and no change event follow, and the block sleeps for SLEEP_TICKS. The latch history is left unchanged.
- R8: After a latch read, every bit of (new XOR previous) that lies in first_slot..last_slot produces one change event, with chg_slot set to that bit number. Events come one per cycle, lowest slot first. The first event appears in the cycle after the read is acknowledged. Bit 0 and bits outside the range never produce an event.
- R9: After reset the previous latch sample is 0x00. The first latch poll therefore reports every in-range slot whose latch bit is set.
- R10: Once req_valid is raised, it stays high with req_index unchanged until the cycle in which ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle time-base pulse from a prescaler |
| first_slot | input | SLOT_W | Lowest physical slot number handled by this controller |
| last_slot | input | SLOT_W | Highest physical slot number handled by this controller |
| req_valid | output | 1 | Read request toward the register-access engine |
| req_index | output | IDX_W | Register index of the pending read |
| ack | input | 1 | One-cycle acknowledge; rdata is valid in the same cycle |
| rdata | input | 8 | Byte returned by the engine |
| chg_valid | output | 1 | One-cycle change event |
| chg_slot | output | SLOT_W | Slot number of the change event |
| timeout_err | output | 1 | One-cycle pulse when the busy wait gives up |

## Verification
The controller model answers with a latch byte that changes from poll to poll. The first poll sets bits on a zero history, which shows the reset value of the history. Other polls set the same byte twice, so no event may follow. Some flip only bit 0 and bit 7, which lie outside the range and show that masking works. The busy count per wait is also varied. A wait of zero extra reads, a wait of one, and one just under the limit each test a different retry gap. A wait of exactly the limit tests the abandoned poll and the history it must keep. Tick pulses come in an uneven pattern, so a gap that the design measures in cycles rather than ticks shows up as a gap-length error.

// File: rtl/hp_poll_pkg.sv
package hp_poll_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP  = 3'd0,
        ST_STAT   = 3'd1,
        ST_RETRY  = 3'd2,
        ST_ACC    = 3'd3,
        ST_REPORT = 3'd4
    } seq_state_e;

    localparam logic [7:0] IDX_CTLR_STAT = 8'h0F;
    localparam logic [7:0] IDX_LATCH     = 8'h28;
    localparam logic [7:0] IDX_EXT_OFS   = 8'h10;

endpackage

// File: rtl/hp_tick_timer.sv
module hp_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = run && tick && (cnt_q == limit - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = '0;
        else if (tick) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2 / R6: a running wait never counts past its limit
    assert_timer_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/hp_slot_mask.sv
module hp_slot_mask #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3
) (
    input  logic [SLOT_W-1:0] first_slot,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [SLOTS-1:0]  latch_new,
    input  logic [SLOTS-1:0]  latch_old,
    input  logic [SLOTS-1:0]  pend,
    output logic [SLOTS-1:0]  changed,
    output logic [SLOTS-1:0]  low_onehot,
    output logic [SLOT_W-1:0] low_slot
);
    logic [SLOTS-1:0] range_mask;

    for (genvar i = 0; i < SLOTS; i++) begin : g_bit
        if (i == 0) begin : g_rsvd
            assign range_mask[i] = 1'b0;
        end else begin : g_slot
            assign range_mask[i] = (SLOT_W'(i) >= first_slot) && (SLOT_W'(i) <= last_slot);
        end
    end

    assign changed    = (latch_new ^ latch_old) & range_mask;
    assign low_onehot = pend & (~pend + SLOTS'(1));

    always_comb begin
        low_slot = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (pend[k]) low_slot = SLOT_W'(k);
        end
    end

endmodule

// File: rtl/hp_poll_seq.sv
module hp_poll_seq
    import hp_poll_pkg::*;
#(
    parameter int SLEEP_TICKS = 2000,
    parameter int RETRY_TICKS = 1000,
    parameter int MAX_RETRY   = 60,
    parameter int FULL_PERIOD = 5,
    parameter int SLOTS       = 8,
    parameter int IDX_W       = 8,
    parameter int SLOT_W      = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] first_slot,
    input  logic [SLOT_W-1:0] last_slot,
    output logic              req_valid,
    output logic [IDX_W-1:0]  req_index,
    input  logic              ack,
    input  logic [7:0]        rdata,
    output logic              chg_valid,
    output logic [SLOT_W-1:0] chg_slot,
    output logic              timeout_err
);
    localparam int MAX_T = (SLEEP_TICKS > RETRY_TICKS) ? SLEEP_TICKS : RETRY_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int PC_W  = $clog2(FULL_PERIOD + 1);
    localparam int RT_W  = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        seq_state_e        st;
        logic              full;
        logic [PC_W-1:0]   poll_cnt;
        logic [SLOT_W-1:0] slot;
        logic              ext;
        logic [RT_W-1:0]   retries;
        logic [SLOTS-1:0]  prev;
        logic [SLOTS-1:0]  pend;
        logic              err;
    } seq_ctx_t;

    seq_ctx_t ctx_d, ctx_q;

    logic             tmr_run, tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    logic [SLOTS-1:0] changed, low_onehot, pend_rest;
    logic [SLOT_W-1:0] low_slot;

    assign tmr_run   = (ctx_q.st == ST_SLEEP) || (ctx_q.st == ST_RETRY);
    assign tmr_limit = (ctx_q.st == ST_SLEEP) ? CNT_W'(SLEEP_TICKS) : CNT_W'(RETRY_TICKS);

    hp_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (tick),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    hp_slot_mask #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_mask (
        .first_slot (first_slot),
        .last_slot  (last_slot),
        .latch_new  (rdata[SLOTS-1:0]),
        .latch_old  (ctx_q.prev),
        .pend       (ctx_q.pend),
        .changed    (changed),
        .low_onehot (low_onehot),
        .low_slot   (low_slot)
    );

    assign pend_rest = ctx_q.pend & ~low_onehot;

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.err = 1'b0;
        unique case (ctx_q.st)
            ST_SLEEP: begin
                if (tmr_done) begin
                    ctx_d.retries = '0;
                    ctx_d.slot    = first_slot;
                    ctx_d.ext     = 1'b0;
                    ctx_d.st      = ST_STAT;
                    if (ctx_q.poll_cnt == PC_W'(FULL_PERIOD)) begin
                        ctx_d.poll_cnt = '0;
                        ctx_d.full     = 1'b1;
                    end else begin
                        ctx_d.poll_cnt = ctx_q.poll_cnt + PC_W'(1);
                        ctx_d.full     = 1'b0;
                    end
                end
            end
            ST_STAT: begin
                if (ack) begin
                    if (rdata[0]) begin
                        if (ctx_q.retries == RT_W'(MAX_RETRY - 1)) begin
                            ctx_d.err = 1'b1;
                            ctx_d.st  = ST_SLEEP;
                        end else begin
                            ctx_d.retries = ctx_q.retries + RT_W'(1);
                            ctx_d.st      = ST_RETRY;
                        end
                    end else begin
                        ctx_d.retries = '0;
                        ctx_d.st      = ST_ACC;
                    end
                end
            end
            ST_RETRY: begin
                if (tmr_done) ctx_d.st = ST_STAT;
            end
            ST_ACC: begin
                if (ack) begin
                    if (!ctx_q.full) begin
                        ctx_d.pend = changed;
                        ctx_d.prev = rdata[SLOTS-1:0];
                        ctx_d.st   = (|changed) ? ST_REPORT : ST_SLEEP;
                    end else if (!ctx_q.ext) begin
                        ctx_d.ext = 1'b1;
                        ctx_d.st  = ST_STAT;
                    end else if (ctx_q.slot == last_slot) begin
                        ctx_d.st = ST_SLEEP;
                    end else begin
                        ctx_d.slot = ctx_q.slot + SLOT_W'(1);
                        ctx_d.ext  = 1'b0;
                        ctx_d.st   = ST_STAT;
                    end
                end
            end
            ST_REPORT: begin
                ctx_d.pend = pend_rest;
                if (pend_rest == '0) ctx_d.st = ST_SLEEP;
            end
            default: ctx_d.st = ST_SLEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q          <= '0;
            ctx_q.st       <= ST_SLEEP;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        req_index = '0;
        if (ctx_q.st == ST_STAT) begin
            req_index = IDX_W'(IDX_CTLR_STAT);
        end else if (!ctx_q.full) begin
            req_index = IDX_W'(IDX_LATCH);
        end else begin
            req_index = IDX_W'(ctx_q.slot) + (ctx_q.ext ? IDX_W'(IDX_EXT_OFS) : IDX_W'(0));
        end
    end

    assign req_valid   = (ctx_q.st == ST_STAT) || (ctx_q.st == ST_ACC);
    assign chg_valid   = (ctx_q.st == ST_REPORT) && (ctx_q.pend != '0);
    assign chg_slot    = low_slot;
    assign timeout_err = ctx_q.err;

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ack) |=> (req_valid && $stable(req_index)));

    assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_valid) |-> $past(ack));

    assert_chg_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> (chg_slot != '0 && chg_slot >= first_slot && chg_slot <= last_slot));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> (!timeout_err && !req_valid));

    assert_poll_cnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.poll_cnt <= PC_W'(FULL_PERIOD));

    assert_retry_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_q.retries < RT_W'(MAX_RETRY));

endmodule

// File: tb/sim_hp_poll_seq.sv
`timescale 1ns/1ps
module sim_hp_poll_seq;
    localparam int SLEEP_T = 3;
    localparam int RETRY_T = 2;
    localparam int MAXR    = 4;
    localparam int FIRST   = 2;
    localparam int LAST    = 6;
    localparam int NPOLLS  = 13;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] first_slot = 3'(FIRST);
    logic [2:0] last_slot  = 3'(LAST);
    logic       req_valid;
    logic [7:0] req_index;
    logic       ack = 1'b0;
    logic [7:0] rdata = 8'h00;
    logic       chg_valid;
    logic [2:0] chg_slot;
    logic       timeout_err;

    always #2.5 clk = ~clk;

    hp_poll_seq #(
        .SLEEP_TICKS(SLEEP_T), .RETRY_TICKS(RETRY_T), .MAX_RETRY(MAXR),
        .FULL_PERIOD(5), .SLOTS(8), .IDX_W(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .first_slot(first_slot), .last_slot(last_slot),
        .req_valid(req_valid), .req_index(req_index),
        .ack(ack), .rdata(rdata),
        .chg_valid(chg_valid), .chg_slot(chg_slot),
        .timeout_err(timeout_err)
    );

    int checks = 0, failures = 0;
    int cyc = 0;
    int poll_idx = 0;
    int busy_left = 0;
    logic [7:0] latch_val = 8'hCD;
    logic [7:0] prev_model = 8'h00;
    int exp_q[$];
    int chg_q[$];
    bit in_poll = 0, ready = 0, exp_err = 0;
    int busy_run = 0, gap_ticks = 0, exp_gap = SLEEP_T;
    bit req_prev = 0, ack_prev = 0;
    logic [7:0] idx_prev = 8'h00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h cycle=%0d", req, act, exp, cyc);
        end
    endtask

    task automatic end_poll();
        in_poll  = 0;
        ready    = 0;
        busy_run = 0;
        exp_q.delete();
        poll_idx++;
        case (poll_idx)
            1:  begin latch_val = 8'hCD; busy_left = 0; end
            2:  begin latch_val = 8'h91; busy_left = 2; end
            3:  begin latch_val = 8'h00; busy_left = MAXR; end
            4:  begin latch_val = 8'h00; busy_left = 0; end
            5:  begin busy_left = 1; end
            6:  begin latch_val = 8'h7E; busy_left = 0; end
            7:  begin latch_val = 8'hFF; busy_left = 0; end
            8:  begin latch_val = 8'h02; busy_left = MAXR - 1; end
            9:  begin latch_val = 8'h02; busy_left = 0; end
            10: begin latch_val = 8'h40; busy_left = 0; end
            11: begin busy_left = 0; end
            default: begin latch_val = 8'h00; busy_left = 0; end
        endcase
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check(req_valid == 1'b0 && chg_valid == 1'b0 && timeout_err == 1'b0,
              "reset", {req_valid, chg_valid, timeout_err}, 0);
        rst_n = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            tick = (cyc % 3) != 0;
            if (req_valid && !ack) begin
                ack = 1'b1;
                if (req_index == 8'h0F) begin
                    if (busy_left > 0) begin rdata = 8'h41; busy_left--; end
                    else rdata = 8'h40;
                end else if (req_index == 8'h28) rdata = latch_val;
                else rdata = req_index ^ 8'hA5;
            end else begin
                ack = 1'b0;
            end
            #1;
            // R7: timeout pulse exactly when predicted
            if (exp_err || timeout_err) check(timeout_err == exp_err, "R7", timeout_err, exp_err);
            exp_err = 0;
            // R8 / R9: change events one per cycle, ascending
            if (chg_q.size() > 0) begin
                check(chg_valid && chg_slot == 3'(chg_q[0]), "R8", {chg_valid, chg_slot}, {1'b1, 3'(chg_q[0])});
                void'(chg_q.pop_front());
            end else if (chg_valid) begin
                check(1'b0, "R8", chg_slot, 0);
            end
            // R10: request held until acknowledged
            if (req_prev && !ack_prev)
                check(req_valid && req_index == idx_prev, "R10", {req_valid, req_index}, {1'b1, idx_prev});
            // R2 / R6: tick gaps
            if (!req_valid && !chg_valid && tick) gap_ticks++;
            if (req_valid && !req_prev) begin
                check(gap_ticks == exp_gap, (exp_gap == SLEEP_T) ? "R2" : "R6", gap_ticks, exp_gap);
                gap_ticks = 0;
            end
            if (req_valid && ack) begin
                if (!in_poll) begin
                    in_poll = 1;
                    if (poll_idx % 6 == 5) begin
                        for (int s = FIRST; s <= LAST; s++) begin
                            exp_q.push_back(s);
                            exp_q.push_back(s + 16);
                        end
                    end else begin
                        exp_q.push_back(8'h28);
                    end
                end
                if (req_index == 8'h0F) begin
                    check(!ready, "R5", ready, 0);
                    if (rdata[0]) begin
                        busy_run++;
                        if (busy_run == MAXR) begin
                            exp_err = 1;
                            exp_gap = SLEEP_T;
                            end_poll();
                        end else begin
                            exp_gap = RETRY_T;
                        end
                    end else begin
                        ready = 1;
                        busy_run = 0;
                    end
                end else begin
                    check(ready, "R5", ready, 1);
                    ready = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1", req_index, 0);
                    end else begin
                        // R3 for latch polls, R4 for full sweeps, R1 for the kind
                        check(req_index == 8'(exp_q[0]), (poll_idx % 6 == 5) ? "R4" : "R3",
                              req_index, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    if (req_index == 8'h28) begin
                        // R9 applies to the first of these: prev_model starts at 0x00
                        for (int b = FIRST; b <= LAST; b++)
                            if (rdata[b] != prev_model[b]) chg_q.push_back(b);
                        prev_model = rdata;
                    end
                    if (exp_q.size() == 0) begin
                        exp_gap = SLEEP_T;
                        end_poll();
                    end
                end
            end
            req_prev = req_valid;
            ack_prev = ack;
            idx_prev = req_index;
            if (poll_idx >= NPOLLS && chg_q.size() == 0) begin
                check(poll_idx == NPOLLS, "R1", poll_idx, NPOLLS);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
            if (cyc > 20000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", poll_idx, NPOLLS);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

endmodule